// File: doc/BRIEF.md
# Serial Pin Expander

This block turns a handful of pins into as many as 80 general-purpose inputs and 80 general-purpose outputs. It does so by running a frame of bits, again and again, through two external shift-register chains. One chain loads its pins in parallel and shifts them out serially. The other chain shifts bits in serially and presents them in parallel when latched. A divider derives the shift clock from the system clock. Each frame starts with a load strobe, followed by one shift-clock pulse per active pin.

Software configures and observes the block through a byte-wide register port. Each address is split into a bank number (bits 7:4) and a field (bits 3:0). Banks 0 to 9 each cover eight pins. Bank 15 holds the global settings: field 0 is control (bit 0 enable, bits 7:4 active bank count), field 1 is the low divisor byte and field 2 is the high divisor byte. The per-bank fields are: 0 output values, 1 input snapshot (read only), 2 interrupt enable, 3 mode bit 0, 4 mode bit 1, 5 interrupt status and 6 soft-reset keep mask. Bit i of a per-bank byte belongs to pin 8*bank+i. Writes to fields or banks not listed here have no effect, and reads of them return 0.

A single interrupt line summarises all enabled pins. A synchronous soft-reset input returns the block to its idle configuration while keeping selected output values.

Top module: `serial_pin_expander`

## Requirements
- R1: The active bank count B is taken from control bits 7:4, and counts above 10 are treated as 10. Every frame issues exactly 8*B shift-clock pulses.
- R2: While enable is 0 or B is 0, no frame starts: `loadStrobe` and `sclk` stay low.
- R3: The shift clock stays high for D+1 system cycles in each pulse, where D is the 16-bit divisor {field 2, field 1} of bank 15. D resets to 0.
- R4: A frame begins with `loadStrobe` high for 2*(D+1) cycles while `sclk` is low. Its rising edge latches the bits of the previous frame into the output chain, and the k-th bit shifted becomes output pin k.
- R5: Output pin 0 is shifted first. `sdataOut` changes only while `sclk` is low and holds steady through each high phase. The values sent are those written to the output fields before the frame began.
- R6: Input pin k is the k-th bit sampled on rising shift-clock edges. The input snapshot field changes only when a frame completes.
- R7: Mode {bit1,bit0} = 00 is level-high and 01 is level-low. The status bit of a pin in a level mode follows its current snapshot value and clears by itself when the condition ends.
- R8: Mode 10 is rising edge and 11 is falling edge. The snapshot of each frame is compared with the snapshot of the previous frame, which is 0 after reset. A detected edge sets a sticky status bit, and writing 1 to that status bit clears it.
- R9: `irq` is high exactly when some pin has both its status bit and its enable bit set. A pin whose enable is 0 does not affect `irq`.
- R10: A soft reset clears control, divisor, enables, modes, status and snapshots, and stops the sequencer. Output bits whose keep-mask bit is 1 keep their value, other output bits clear, and the keep mask itself is retained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| softReset | input | 1 | Synchronous soft reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 8 | Write address {bank, field} |
| wrData | input | 8 | Write data |
| rdAddr | input | 8 | Read address {bank, field} |
| rdData | output | 8 | Read data, combinational from rdAddr |
| sdataIn | input | 1 | Serial data from the input chain |
| sdataOut | output | 1 | Serial data to the output chain |
| sclk | output | 1 | Shift clock to both chains |
| loadStrobe | output | 1 | Input capture / output latch strobe |
| irq | output | 1 | Combined interrupt |

## Verification
The bench models both external chains. It checks the frame geometry: the high width of the shift clock, the width of the load strobe and the number of pulses per frame. It uses both a single-bank frame with no division and a clamped 12-bank request with a divisor of 3. A design that miscounted pulses would shift the data by one pin or drop the last byte. A design with an off-by-one divider would show a high width of D or D+2 cycles. The bench reads the input snapshot straight after changing the pins, and a design that let captured bits leak out before the frame completes shows the new value at that read. It also drives each interrupt mode through assertion and release. A design that cleared edge bits on the reverse edge, latched level bits, or let a disabled pin reach `irq` fails those reads. Finally, the bench soft-resets with a partial keep mask, which catches a design that wipes every output or keeps every output.

// File: rtl/spx_pkg.sv
package spx_pkg;
  localparam int MaxBanks = 10;
  localparam int PinCount = MaxBanks * 8;
  localparam int IdxW = $clog2(PinCount);
  localparam int BankSelW = 4;
  localparam int DivW = 16;
  localparam logic [BankSelW-1:0] GlobalBank = 4'hF;
  localparam logic [3:0] FldCtrl = 4'd0;
  localparam logic [3:0] FldDivLo = 4'd1;
  localparam logic [3:0] FldDivHi = 4'd2;
  localparam logic [3:0] FldOut = 4'd0;
  localparam logic [3:0] FldIn = 4'd1;
  localparam logic [3:0] FldEn = 4'd2;
  localparam logic [3:0] FldMode0 = 4'd3;
  localparam logic [3:0] FldMode1 = 4'd4;
  localparam logic [3:0] FldStat = 4'd5;
  localparam logic [3:0] FldKeep = 4'd6;

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_SHIFT} seqState_t;

  typedef struct packed {
    logic startFrame;
    logic sampleBit;
    logic frameDone;
    logic [IdxW-1:0] bitIdx;
  } seqStrobe_t;
endpackage

// File: rtl/spx_sequencer.sv
module spx_sequencer
  import spx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                softReset,
  input  logic                cfgEnable,
  input  logic [BankSelW-1:0] cfgBanks,
  input  logic [DivW-1:0]     cfgDiv,
  output logic                sclk,
  output logic                loadStrobe,
  output seqStrobe_t          strobes
);
  seqState_t state;
  logic phase;
  logic [DivW-1:0] divCnt;
  logic [IdxW-1:0] bitCnt, frameBits, nextBits;
  logic [BankSelW-1:0] effBanks;
  logic go, tick, lastBit;

  always_comb begin
    effBanks = (cfgBanks > BankSelW'(MaxBanks)) ? BankSelW'(MaxBanks) : cfgBanks;
    nextBits = IdxW'({effBanks, 3'b000});
    go = cfgEnable && (effBanks != '0);
    tick = (state != S_IDLE) && (divCnt >= cfgDiv);
    lastBit = (bitCnt == frameBits - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; phase <= 1'b0; divCnt <= '0; bitCnt <= '0; frameBits <= '0;
    end else if (softReset) begin
      state <= S_IDLE; phase <= 1'b0; divCnt <= '0; bitCnt <= '0; frameBits <= '0;
    end else if (state == S_IDLE) begin
      divCnt <= '0;
      if (go) begin
        state <= S_LOAD; phase <= 1'b0; bitCnt <= '0; frameBits <= nextBits;
      end
    end else begin
      divCnt <= tick ? '0 : divCnt + 1'b1;
      if (tick) begin
        if (state == S_LOAD) begin
          if (phase) state <= S_SHIFT;
          phase <= ~phase;
        end else if (!phase) begin
          phase <= 1'b1;
        end else begin
          phase <= 1'b0;
          if (lastBit) begin
            bitCnt <= '0;
            if (go) begin
              state <= S_LOAD; frameBits <= nextBits;
            end else begin
              state <= S_IDLE;
            end
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    sclk = (state == S_SHIFT) && phase;
    loadStrobe = (state == S_LOAD);
    strobes.frameDone = (state == S_SHIFT) && tick && phase && lastBit;
    strobes.startFrame = ((state == S_IDLE) && go) || (strobes.frameDone && go);
    strobes.sampleBit = (state == S_SHIFT) && tick && !phase;
    strobes.bitIdx = bitCnt;
  end

  a_r4_load_sclk_low: assert property (@(posedge clk) disable iff (!rst_n)
    loadStrobe |-> !sclk);
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && !go) |=> (state == S_IDLE));
  a_r1_bit_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SHIFT) |-> (bitCnt < frameBits));
  a_r3_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE && !tick && !softReset) |=> $stable(sclk));
endmodule

// File: rtl/spx_datapath.sv
module spx_datapath
  import spx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                softReset,
  input  logic                wrEn,
  input  logic [7:0]          wrAddr,
  input  logic [7:0]          wrData,
  input  logic [7:0]          rdAddr,
  output logic [7:0]          rdData,
  input  seqStrobe_t          strobes,
  input  logic                sdataIn,
  output logic                sdataOut,
  output logic                cfgEnable,
  output logic [BankSelW-1:0] cfgBanks,
  output logic [DivW-1:0]     cfgDiv,
  output logic                irq
);
  logic [PinCount-1:0] outVal, outSnap, intEn, mode0, mode1, keepMask;
  logic [PinCount-1:0] sticky, inSnap, capBits, edgeEv, stsClr, statusView;
  logic [BankSelW-1:0] wrBank, rdBank;
  logic [3:0] wrField, rdField;
  logic statWrite;

  assign wrBank = wrAddr[7:4];
  assign wrField = wrAddr[3:0];
  assign rdBank = rdAddr[7:4];
  assign rdField = rdAddr[3:0];
  assign statWrite = wrEn && (wrField == FldStat) && (wrBank < BankSelW'(MaxBanks));

  for (genvar i = 0; i < PinCount; i++) begin : g_pin
    logic wentUp, wentDown, levelHit;
    assign wentUp = strobes.frameDone && !inSnap[i] && capBits[i];
    assign wentDown = strobes.frameDone && inSnap[i] && !capBits[i];
    assign edgeEv[i] = mode1[i] && (mode0[i] ? wentDown : wentUp);
    assign stsClr[i] = wrEn && (wrField == FldStat) && (wrBank == BankSelW'(i / 8)) && wrData[i % 8];
    assign levelHit = mode0[i] ? !inSnap[i] : inSnap[i];
    assign statusView[i] = mode1[i] ? sticky[i] : levelHit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfgEnable <= 1'b0; cfgBanks <= '0; cfgDiv <= '0;
      outVal <= '0; intEn <= '0; mode0 <= '0; mode1 <= '0; keepMask <= '0;
    end else if (softReset) begin
      cfgEnable <= 1'b0; cfgBanks <= '0; cfgDiv <= '0;
      outVal <= outVal & keepMask; intEn <= '0; mode0 <= '0; mode1 <= '0;
    end else if (wrEn) begin
      if (wrBank == GlobalBank) begin
        case (wrField)
          FldCtrl:  begin cfgEnable <= wrData[0]; cfgBanks <= wrData[7:4]; end
          FldDivLo: cfgDiv[7:0] <= wrData;
          FldDivHi: cfgDiv[15:8] <= wrData;
          default: ;
        endcase
      end
      for (int b = 0; b < MaxBanks; b++) begin
        if (wrBank == BankSelW'(b)) begin
          case (wrField)
            FldOut:   outVal[b*8 +: 8] <= wrData;
            FldEn:    intEn[b*8 +: 8] <= wrData;
            FldMode0: mode0[b*8 +: 8] <= wrData;
            FldMode1: mode1[b*8 +: 8] <= wrData;
            FldKeep:  keepMask[b*8 +: 8] <= wrData;
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky <= '0; inSnap <= '0; capBits <= '0; outSnap <= '0;
    end else if (softReset) begin
      sticky <= '0; inSnap <= '0; capBits <= '0; outSnap <= '0;
    end else begin
      sticky <= edgeEv | (sticky & ~stsClr);
      if (strobes.frameDone) inSnap <= capBits;
      if (strobes.startFrame) begin
        capBits <= '0;
        outSnap <= outVal;
      end else if (strobes.sampleBit) begin
        capBits[strobes.bitIdx] <= sdataIn;
      end
    end
  end

  assign sdataOut = outSnap[strobes.bitIdx];
  assign irq = |(statusView & intEn);

  always_comb begin
    rdData = '0;
    if (rdBank == GlobalBank) begin
      case (rdField)
        FldCtrl:  rdData = {cfgBanks, 3'b000, cfgEnable};
        FldDivLo: rdData = cfgDiv[7:0];
        FldDivHi: rdData = cfgDiv[15:8];
        default: ;
      endcase
    end
    for (int b = 0; b < MaxBanks; b++) begin
      if (rdBank == BankSelW'(b)) begin
        case (rdField)
          FldOut:   rdData = outVal[b*8 +: 8];
          FldIn:    rdData = inSnap[b*8 +: 8];
          FldEn:    rdData = intEn[b*8 +: 8];
          FldMode0: rdData = mode0[b*8 +: 8];
          FldMode1: rdData = mode1[b*8 +: 8];
          FldStat:  rdData = statusView[b*8 +: 8];
          FldKeep:  rdData = keepMask[b*8 +: 8];
          default: ;
        endcase
      end
    end
  end

  a_r8_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobes.frameDone && !statWrite && !softReset) |=> $stable(sticky));
  a_r6_snapshot_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobes.frameDone && !softReset) |=> $stable(inSnap));
  a_r10_keep_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    softReset |=> ((outVal & keepMask) == ($past(outVal) & $past(keepMask))));
endmodule

// File: rtl/serial_pin_expander.sv
module serial_pin_expander
  import spx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       softReset,
  input  logic       wrEn,
  input  logic [7:0] wrAddr,
  input  logic [7:0] wrData,
  input  logic [7:0] rdAddr,
  output logic [7:0] rdData,
  input  logic       sdataIn,
  output logic       sdataOut,
  output logic       sclk,
  output logic       loadStrobe,
  output logic       irq
);
  seqStrobe_t strobes;
  logic cfgEnable;
  logic [BankSelW-1:0] cfgBanks;
  logic [DivW-1:0] cfgDiv;

  spx_sequencer u_seq (
    .clk(clk), .rst_n(rst_n), .softReset(softReset), .cfgEnable(cfgEnable),
    .cfgBanks(cfgBanks), .cfgDiv(cfgDiv), .sclk(sclk), .loadStrobe(loadStrobe),
    .strobes(strobes)
  );

  spx_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .softReset(softReset), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .strobes(strobes),
    .sdataIn(sdataIn), .sdataOut(sdataOut), .cfgEnable(cfgEnable),
    .cfgBanks(cfgBanks), .cfgDiv(cfgDiv), .irq(irq)
  );

  a_r5_data_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(sdataOut));
endmodule

// File: tb/tb_serial_pin_expander.sv
module tb_serial_pin_expander;
  logic clk = 1'b0, rst_n = 1'b0, softReset = 1'b0, wrEn = 1'b0;
  logic [7:0] wrAddr = '0, wrData = '0, rdAddr = '0, rdData;
  logic sdataIn, sdataOut, sclk, loadStrobe, irq;

  serial_pin_expander dut (.*);

  always #10 clk = ~clk;

  int errors = 0, checks = 0;
  bit finished = 0;
  logic [79:0] extIn = '0, capt = '0, outPins = '0, expOut;
  int ptr = 0, loadRises = 0, sclkRises = 0, pulses = 0, lastPulses = 0;
  int hiRun = 0, lastHi = 0, loadRun = 0, lastLoad = 0;
  logic prevLoad = 0, prevSclk = 0, prevOut = 0;
  bit outQ[$];
  logic [7:0] rv;

  assign sdataIn = (ptr < 80) ? capt[ptr] : 1'b0;

  task automatic chk(input string tag, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural model of the two external chains plus per-clock protocol checks
  always @(negedge clk) begin
    if (!rst_n) begin
      ptr = 0; outQ.delete(); hiRun = 0; loadRun = 0; pulses = 0;
    end else begin
      if (loadStrobe) begin capt = extIn; ptr = 0; end
      if (loadStrobe && !prevLoad) begin
        loadRises++; lastPulses = pulses; pulses = 0;
        for (int k = 0; k < outQ.size(); k++) outPins[k] = outQ[k];
        outQ.delete();
      end
      if (sclk && !prevSclk) begin
        outQ.push_back(sdataOut); ptr++; pulses++; sclkRises++;
      end
      if (sclk) hiRun++; else begin if (prevSclk) lastHi = hiRun; hiRun = 0; end
      if (loadStrobe) loadRun++; else begin if (prevLoad) lastLoad = loadRun; loadRun = 0; end
      if (sclk && loadStrobe) chk("R4 sclk during load", 1, 0);
      if (sclk && prevSclk) chk("R5 data steady while sclk high", sdataOut, prevOut);
      prevLoad = loadStrobe; prevSclk = sclk; prevOut = sdataOut;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); rdAddr = a; #1 d = rdData;
  endtask

  task automatic waitFrames(input int n);
    int target;
    target = loadRises + n;
    while (loadRises < target) @(negedge clk);
    #2;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int rises;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    // reset state
    rd(8'hF1, rv); chk("R3 divisor low reset", rv, 0);
    rd(8'hF2, rv); chk("R3 divisor high reset", rv, 0);
    rd(8'hF0, rv); chk("R2 control reset", rv, 0);
    chk("R2 idle outputs after reset", {sclk, loadStrobe, irq}, 0);

    // R2: enable with no banks, then banks without enable
    wr(8'hF0, 8'h01); repeat (100) @(negedge clk);
    chk("R2 no frames with zero banks", loadRises + sclkRises, 0);
    wr(8'hF0, 8'hA0); repeat (100) @(negedge clk);
    chk("R2 no frames while disabled", loadRises + sclkRises, 0);

    // single bank, divisor 0
    extIn[7:0] = 8'h3C;
    wr(8'h00, 8'hA5);
    wr(8'hF0, 8'h11);
    waitFrames(4);
    chk("R3 high width D=0", lastHi, 1);
    chk("R4 load width D=0", lastLoad, 2);
    chk("R1 pulses one bank", lastPulses, 8);
    chk("R4 R5 output pins bank0", outPins[7:0], 8'hA5);
    rd(8'h01, rv); chk("R6 input snapshot bank0", rv, 8'h3C);

    // clamped bank count (12 -> 10), divisor 3
    extIn = 80'h1234_5678_9ABC_DEF0_1357;
    for (int b = 0; b < 10; b++) begin
      wr({b[3:0], 4'h0}, 8'(b * 17 + 1));
      expOut[b*8 +: 8] = 8'(b * 17 + 1);
    end
    wr(8'hF1, 8'h03);
    wr(8'hF0, 8'hC1);
    waitFrames(3);
    chk("R3 high width D=3", lastHi, 4);
    chk("R4 load width D=3", lastLoad, 8);
    chk("R1 pulses clamped to 80", lastPulses, 80);
    chk("R4 R5 all output pins", outPins, expOut);
    for (int b = 0; b < 10; b++) begin
      rd({b[3:0], 4'h1}, rv); chk("R6 input snapshot all banks", rv, extIn[b*8 +: 8]);
    end
    // R6: snapshot does not move before a frame completes
    extIn[7:0] = 8'hC3;
    rd(8'h01, rv); chk("R6 snapshot unchanged mid-frame", rv, 8'h57);
    waitFrames(3);
    rd(8'h01, rv); chk("R6 snapshot after frames", rv, 8'hC3);

    // interrupts on bank 0, fast frames
    wr(8'hF1, 8'h00); wr(8'hF0, 8'h11);
    extIn[7:0] = 8'b0000_1010;
    wr(8'h03, 8'b0000_1010);   // mode bit0: pins 1,3
    wr(8'h04, 8'b0000_1001);   // mode bit1: pins 0,3
    waitFrames(3);
    wr(8'h05, 8'hFF);
    wr(8'h02, 8'h0F);
    rd(8'h05, rv); chk("R8 status after clear", rv, 8'h00);
    chk("R9 irq quiet", irq, 0);
    extIn[0] = 1'b1; extIn[4] = 1'b1;
    waitFrames(3);
    rd(8'h05, rv); chk("R8 rising edge sticky set", rv, 8'h11);
    chk("R9 irq from enabled pin", irq, 1);
    extIn[0] = 1'b0;
    waitFrames(3);
    rd(8'h05, rv); chk("R8 sticky survives release", rv, 8'h11);
    wr(8'h05, 8'h01);
    rd(8'h05, rv); chk("R8 write one clears", rv, 8'h10);
    chk("R9 disabled pin ignored", irq, 0);
    extIn[2] = 1'b1; waitFrames(3);
    rd(8'h05, rv); chk("R7 level-high asserted", rv, 8'h14);
    chk("R9 irq level-high", irq, 1);
    extIn[2] = 1'b0; waitFrames(3);
    rd(8'h05, rv); chk("R7 level-high self clears", rv, 8'h10);
    chk("R9 irq drops", irq, 0);
    extIn[1] = 1'b0; waitFrames(3);
    rd(8'h05, rv); chk("R7 level-low asserted", rv, 8'h12);
    extIn[1] = 1'b1; waitFrames(3);
    rd(8'h05, rv); chk("R7 level-low self clears", rv, 8'h10);
    extIn[3] = 1'b0; waitFrames(3);
    rd(8'h05, rv); chk("R8 falling edge set", rv, 8'h18);
    chk("R9 irq falling", irq, 1);
    extIn[3] = 1'b1; waitFrames(3);
    rd(8'h05, rv); chk("R8 falling not cleared by rise", rv, 8'h18);
    wr(8'h05, 8'h08);
    rd(8'h05, rv); chk("R8 falling cleared by write", rv, 8'h10);

    // soft reset with partial keep mask
    wr(8'h06, 8'h0F);
    wr(8'h00, 8'hF3);
    @(negedge clk); softReset = 1'b1; @(negedge clk); softReset = 1'b0;
    rd(8'h00, rv); chk("R10 kept outputs", rv, 8'h03);
    rd(8'h06, rv); chk("R10 keep mask retained", rv, 8'h0F);
    rd(8'hF0, rv); chk("R10 control cleared", rv, 8'h00);
    rd(8'h02, rv); chk("R10 enables cleared", rv, 8'h00);
    rises = sclkRises + loadRises;
    repeat (50) @(negedge clk);
    chk("R10 R2 sequencer stopped", sclkRises + loadRises, rises);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule